// File: doc/BRIEF.md
# Input Capture Channel

This block is one capture channel that timestamps activity on an external input. The pin is brought into the clock domain, its edges are found, and on each qualifying event the present count of one of two free-running 16-bit timers is stored in a capture register. The stored value is read as a high byte and a low byte. An interrupt flag is raised with each capture and stays raised until software clears it. There is no overrun protection: a newer capture simply replaces an older one that has not been read.

Software writes a 4-bit mode field and a timer-select bit through a one-cycle write strobe. The mode picks the event: every falling edge, every rising edge, every 4th rising edge, or every 16th rising edge. Every other value turns capture off. A mode state machine holds the decoded mode in one of five states: `ST_OFF`, `ST_FALL`, `ST_RISE`, `ST_DIV4` and `ST_DIV16`. Any state moves to the state decoded from `cfg_mode` on a write, and stays put otherwise.

Two details follow from that state machine. The rising-edge prescale counter is cleared only while the machine is in `ST_OFF`. A write that moves it straight from one capture state to a different capture state raises a spurious flag. Writing the off mode first avoids both the stale count and the false flag.

Top module: `icap_channel`

## Requirements
- R1: After reset `cap_flag` is 0, `{cap_hi,cap_lo}` is 16'h0000 and the channel is off.
- R2: With mode 4'b0101, every rising pin edge captures the selected timer into `{cap_hi,cap_lo}` and sets `cap_flag`. Both updates happen on the third rising clock edge after the pin changes: two synchroniser flops plus one edge-history flop.
- R3: With mode 4'b0100, every falling pin edge captures and sets the flag with the same latency. Rising edges do not capture.
- R4: With mode 4'b0110 entered from off, a capture occurs on the 4th rising edge and not before.
- R5: With mode 4'b0111 entered from off, a capture occurs on the 16th rising edge and not before.
- R6: `cfg_tsel` = 0 selects `timer_a` and `cfg_tsel` = 1 selects `timer_b`. The value is latched on a write.
- R7: `cap_flag` stays set until `flag_clr` is high. A clear in the same cycle as a capture or spurious set leaves the flag set.
- R8: A capture overwrites an unread earlier capture. The capture value changes only with a flag set.
- R9: In mode 4'b0000 no pin edge captures or sets the flag, and the prescale counter returns to zero.
- R10: A direct write from one prescale mode to the other keeps the count. After 6 rising edges under 4'b0111, a switch to 4'b0110 captures on the 2nd following rising edge.
- R11: A write that moves the channel directly between two different capture modes sets `cap_flag` without changing the capture value. Rewriting the same mode, or entering a mode from off, does not set it.
- R12: Every mode value outside 4'b0100..4'b0111 (for example 4'b1001 or 4'b0011) is treated as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External capture pin, asynchronous |
| timer_a | input | 16 | Count of the first timer |
| timer_b | input | 16 | Count of the second timer |
| cfg_we | input | 1 | Write strobe for mode and timer select |
| cfg_mode | input | 4 | Mode field |
| cfg_tsel | input | 1 | Timer select (0 = timer_a, 1 = timer_b) |
| flag_clr | input | 1 | Software clear of the capture flag |
| cap_hi | output | 8 | Captured value, upper byte |
| cap_lo | output | 8 | Captured value, lower byte |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A wrong mode state shows up at the first qualifying pin edge. In that case a capture is missing or unexpected, or the edge polarity is wrong, three clocks after the pin moves. A prescale counter that is corrupted or not cleared stays hidden until a prescale mode is active. It then moves the capture by whole pin edges, up to 15 edges late, so the bench counts exact edge numbers after both cleared and uncleared entries. Flag errors appear within one clock of a write or a clear, and are checked by the spurious-flag and clear-collision cases.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_FALL  = 3'd1,
        ST_RISE  = 3'd2,
        ST_DIV4  = 3'd3,
        ST_DIV16 = 3'd4
    } cap_state_e;

    localparam logic [3:0] MODE_OFF   = 4'b0000;
    localparam logic [3:0] MODE_FALL  = 4'b0100;
    localparam logic [3:0] MODE_RISE  = 4'b0101;
    localparam logic [3:0] MODE_DIV4  = 4'b0110;
    localparam logic [3:0] MODE_DIV16 = 4'b0111;

    // Map the software mode field onto a state; unknown codes mean off.
    function automatic cap_state_e decode_mode(input logic [3:0] m);
        cap_state_e s;
        case (m)
            MODE_FALL:  s = ST_FALL;
            MODE_RISE:  s = ST_RISE;
            MODE_DIV4:  s = ST_DIV4;
            MODE_DIV16: s = ST_DIV16;
            default:    s = ST_OFF;
        endcase
        return s;
    endfunction

    function automatic logic is_prescaled(input cap_state_e s);
        return (s == ST_DIV4) || (s == ST_DIV16);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          hist;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], pin_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[LAST];
    end

    always_comb begin
        rise = chain[LAST] & ~hist;
        fall = ~chain[LAST] & hist;
    end
endmodule

// File: rtl/icap_mode_fsm.sv
module icap_mode_fsm
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [3:0] cfg_mode,
    input  logic       cfg_tsel,
    output cap_state_e state,
    output logic       tsel_q,
    output logic       spurious
);
    cap_state_e state_nx;
    cap_state_e req_state;

    always_comb req_state = decode_mode(cfg_mode);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            tsel_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (cfg_we) tsel_q <= cfg_tsel;
        end
    end

    // Next state: every state follows a write, holds otherwise
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (cfg_we) state_nx = req_state;
            ST_FALL:  if (cfg_we) state_nx = req_state;
            ST_RISE:  if (cfg_we) state_nx = req_state;
            ST_DIV4:  if (cfg_we) state_nx = req_state;
            ST_DIV16: if (cfg_we) state_nx = req_state;
            default:  state_nx = ST_OFF;
        endcase
    end

    // Outputs: a direct hop between two distinct capture states is spurious
    always_comb begin
        spurious = 1'b0;
        unique case (state)
            ST_OFF:  spurious = 1'b0;
            ST_FALL, ST_RISE, ST_DIV4, ST_DIV16:
                spurious = cfg_we && (req_state != ST_OFF) && (req_state != state);
            default: spurious = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_event_gen.sv
module icap_event_gen
    import icap_pkg::*;
#(
    parameter int PS_BITS    = 4,
    parameter int SMALL_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cap_state_e         state,
    input  logic               rise,
    input  logic               fall,
    output logic               cap_event,
    output logic [PS_BITS-1:0] ps_count
);
    localparam logic [PS_BITS-1:0]    FULL_MAX  = '1;
    localparam logic [SMALL_BITS-1:0] SMALL_MAX = '1;

    // Shared wrapping counter; cleared only while off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_count <= '0;
        else if (state == ST_OFF)
            ps_count <= '0;
        else if (rise && is_prescaled(state))
            ps_count <= ps_count + 1'b1;
    end

    always_comb begin
        cap_event = 1'b0;
        unique case (state)
            ST_OFF:   cap_event = 1'b0;
            ST_FALL:  cap_event = fall;
            ST_RISE:  cap_event = rise;
            ST_DIV4:  cap_event = rise && (ps_count[SMALL_BITS-1:0] == SMALL_MAX);
            ST_DIV16: cap_event = rise && (ps_count == FULL_MAX);
            default:  cap_event = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_event,
    input  logic          spurious,
    input  logic          flag_clr,
    input  logic          tsel,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    output logic [TW-1:0] cap_value,
    output logic          cap_flag
);
    logic [TW-1:0] picked;

    always_comb picked = tsel ? timer_b : timer_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_value <= '0;
            cap_flag  <= 1'b0;
        end else begin
            if (cap_event) cap_value <= picked;
            // set wins over a simultaneous clear
            cap_flag <= cap_event | spurious | (cap_flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PS_BITS     = 4,
    parameter int SMALL_BITS  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_mode,
    input  logic          cfg_tsel,
    input  logic          flag_clr,
    output logic [TW/2-1:0] cap_hi,
    output logic [TW/2-1:0] cap_lo,
    output logic          cap_flag
);
    localparam int HALF = TW / 2;

    logic               rise_w, fall_w;
    cap_state_e         state_w;
    logic               tsel_w, spurious_w, event_w;
    logic [PS_BITS-1:0] ps_count;
    logic [TW-1:0]      cap_value;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .rise(rise_w), .fall(fall_w)
    );

    icap_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .state(state_w), .tsel_q(tsel_w),
        .spurious(spurious_w)
    );

    icap_event_gen #(.PS_BITS(PS_BITS), .SMALL_BITS(SMALL_BITS)) u_evt (
        .clk(clk), .rst_n(rst_n), .state(state_w), .rise(rise_w),
        .fall(fall_w), .cap_event(event_w), .ps_count(ps_count)
    );

    icap_latch #(.TW(TW)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap_event(event_w), .spurious(spurious_w),
        .flag_clr(flag_clr), .tsel(tsel_w), .timer_a(timer_a),
        .timer_b(timer_b), .cap_value(cap_value), .cap_flag(cap_flag)
    );

    always_comb begin
        cap_hi = cap_value[TW-1:HALF];
        cap_lo = cap_value[HALF-1:0];
    end
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk
    import icap_pkg::*;
#(
    parameter int TW      = 16,
    parameter int PS_BITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flag_clr,
    input logic               cap_flag,
    input logic [TW-1:0]      cap_value,
    input cap_state_e         state,
    input logic [PS_BITS-1:0] ps_count
);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R7
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> $past(flag_clr));

    // R8
    value_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_flag);

    // R9
    off_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> $stable(cap_value));

    // R9
    off_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (ps_count == '0));

    // R12
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_OFF, ST_FALL, ST_RISE, ST_DIV4, ST_DIV16});
endmodule

bind icap_channel icap_channel_chk #(.TW(TW), .PS_BITS(PS_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .cap_flag(cap_flag),
    .cap_value(cap_value), .state(state_w), .ps_count(ps_count)
);

// File: tb/tb_icap_channel.sv
module tb_icap_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] timer_a = '0;
    logic [15:0] timer_b = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic        cfg_tsel = 1'b0;
    logic        flag_clr = 1'b0;
    logic [7:0]  cap_hi, cap_lo;
    logic        cap_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    icap_channel dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_a(timer_a),
        .timer_b(timer_b), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .flag_clr(flag_clr), .cap_hi(cap_hi),
        .cap_lo(cap_lo), .cap_flag(cap_flag)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic        tsel;
        logic [15:0] ta;
        logic [15:0] tb;
        logic [7:0]  pulses;
        logic        flag;
        logic [15:0] cap;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0101, 1'b0, 16'h1234, 16'hABCD, 8'd1,  1'b1, 16'h1234, 8'd2},  // R2
        '{4'b0101, 1'b1, 16'h1111, 16'hABCD, 8'd1,  1'b1, 16'hABCD, 8'd6},  // R6
        '{4'b0100, 1'b0, 16'h0F0F, 16'h2222, 8'd1,  1'b1, 16'h0F0F, 8'd3},  // R3
        '{4'b0110, 1'b0, 16'h3333, 16'h2222, 8'd3,  1'b0, 16'h0F0F, 8'd4},  // R4
        '{4'b0110, 1'b1, 16'h3333, 16'h4444, 8'd4,  1'b1, 16'h4444, 8'd4},  // R4
        '{4'b0111, 1'b0, 16'h5555, 16'h4444, 8'd15, 1'b0, 16'h4444, 8'd5},  // R5
        '{4'b0111, 1'b0, 16'h6666, 16'h4444, 8'd16, 1'b1, 16'h6666, 8'd5},  // R5
        '{4'b0000, 1'b0, 16'h7777, 16'h4444, 8'd2,  1'b0, 16'h6666, 8'd9},  // R9
        '{4'b1001, 1'b0, 16'h8888, 16'h4444, 8'd2,  1'b0, 16'h6666, 8'd12}, // R12
        '{4'b0011, 1'b0, 16'h9999, 16'h4444, 8'd2,  1'b0, 16'h6666, 8'd12}  // R12
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] m, input logic t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_tsel = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1;
            repeat (4) @(negedge clk);
            pin_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flag", {15'd0, cap_flag}, 16'd0);
        check("R1 value", {cap_hi, cap_lo}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        pulses(1);
        check("R1 off after reset", {15'd0, cap_flag}, 16'd0);

        // Table walk: each entry enters its mode from off
        for (int v = 0; v < NV; v++) begin
            write_cfg(4'b0000, 1'b0);
            clear_flag();
            timer_a = VECS[v].ta;
            timer_b = VECS[v].tb;
            write_cfg(VECS[v].mode, VECS[v].tsel);
            pulses(int'(VECS[v].pulses));
            repeat (2) @(negedge clk);
            check($sformatf("R%0d flag vec%0d", VECS[v].req, v), {15'd0, cap_flag}, {15'd0, VECS[v].flag});
            check($sformatf("R%0d value vec%0d", VECS[v].req, v), {cap_hi, cap_lo}, VECS[v].cap);
        end

        // R2 latency: capture exactly on third clock edge
        write_cfg(4'b0000, 1'b0);
        clear_flag();
        timer_a = 16'hC001;
        write_cfg(4'b0101, 1'b0);
        pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 not yet", {15'd0, cap_flag}, 16'd0);
        @(negedge clk);
        check("R2 third edge", {cap_hi, cap_lo}, 16'hC001);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7: sticky, then clear colliding with a capture
        repeat (10) @(negedge clk);
        check("R7 sticky", {15'd0, cap_flag}, 16'd1);
        timer_a = 16'hC002;
        pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R7 set beats clear", {15'd0, cap_flag}, 16'd1);
        check("R8 overwrite", {cap_hi, cap_lo}, 16'hC002);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        clear_flag();
        check("R7 cleared", {15'd0, cap_flag}, 16'd0);

        // R11: direct hop rise -> fall raises flag, value unchanged
        write_cfg(4'b0100, 1'b0);
        check("R11 spurious flag", {15'd0, cap_flag}, 16'd1);
        check("R11 value kept", {cap_hi, cap_lo}, 16'hC002);
        clear_flag();
        write_cfg(4'b0100, 1'b0);
        check("R11 same mode quiet", {15'd0, cap_flag}, 16'd0);

        // R10: count survives div16 -> div4
        write_cfg(4'b0000, 1'b0);
        write_cfg(4'b0111, 1'b0);
        check("R11 from off quiet", {15'd0, cap_flag}, 16'd0);
        pulses(6);
        write_cfg(4'b0110, 1'b0);
        clear_flag();
        timer_a = 16'hD00D;
        pulses(1);
        check("R10 one edge after switch", {15'd0, cap_flag}, 16'd0);
        pulses(1);
        check("R10 second edge captures", {cap_hi, cap_lo}, 16'hD00D);

        // R9: off clears a partly advanced count
        write_cfg(4'b0000, 1'b0);
        clear_flag();
        write_cfg(4'b0110, 1'b0);
        pulses(2);
        write_cfg(4'b0000, 1'b0);
        write_cfg(4'b0110, 1'b0);
        pulses(3);
        check("R9 count cleared", {15'd0, cap_flag}, 16'd0);
        pulses(1);
        check("R9 fourth edge", {15'd0, cap_flag}, 16'd1);

        finish_run();
    end
endmodule